// File: doc/BRIEF.md
# Residue Number System Arithmetic Unit

This block adds or multiplies two integers held as residues, with no carry between digits. Each operand is reduced against four pairwise coprime moduli: 5, 7, 9 and 4. Each residue digit is then worked on its own lane, and the result is taken modulo that lane's modulus. The moduli multiply to 1260, so every result is the true sum or product reduced modulo 1260.

The operands arrive as plain binary integers. A converter at the input turns each one into residue form, so a driver can apply ordinary numbers. Conversion and arithmetic happen in one combinational stage. The packed residue result and a valid flag are registered, so a request sampled on one rising edge appears on the outputs right after that edge. The block does not convert results back to binary and does not compare magnitudes.

Top module: `rns_alu`

## Requirements
- R1: The result word is 12 bits wide and packs the digits as follows:
  - bits [2:0] hold the residue mod 5;
  - bits [5:3] hold the residue mod 7;
  - bits [9:6] hold the residue mod 9;
  - bits [11:10] hold the residue mod 4.
- R2: With `op_mul` = 0, each digit of the result equals the sum of the matching operand digits, reduced by that digit's modulus. For example, 29 + 27 gives digits (1,0,2,0).
- R3: With `op_mul` = 1, each digit of the result equals the product of the matching operand digits, reduced by that digit's modulus. For example, 10 × 17 gives digits (0,2,8,2).
- R4: The operation select is sampled together with the operands. Value 0 selects addition and value 1 selects multiplication.
- R5: A request sampled on a rising edge with `in_valid` = 1 sets `out_valid` = 1 after that edge and shows its result in the same cycle.
- R6: On an edge where `in_valid` = 0, `out_valid` becomes 0 and `result` keeps its previous value, whatever the operand and op inputs are.
- R7: On an edge where `rst` is 1 (synchronous, active high), `out_valid` becomes 0 and `result` becomes all zero.
- R8: Each digit of a valid result is strictly smaller than its modulus.
- R9: A binary input v (0 to 2047) enters as the digits (v mod 5, v mod 7, v mod 9, v mod 4). For example:
  - 12 gives (2,5,3,0);
  - 19 gives (4,5,1,3);
  - an input of 1260 or more behaves as v − 1260.
- R10: Results wrap modulo 1260. For example:
  - 1259 + 1 gives (0,0,0,0);
  - 1259 × 1259 gives (1,1,1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for this cycle |
| op_mul | input | 1 | 0 = add, 1 = multiply |
| a_bin | input | 11 | First operand as a binary integer |
| b_bin | input | 11 | Second operand as a binary integer |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 12 | Packed residue digits of the result |

## Verification
The bench builds the block with the default moduli 5, 7, 9 and 4. With these values the whole dynamic range of 1260 values is small, so the bench can reach the wrap point and the largest product directly. The 11-bit inputs also let the bench apply operands above the range, up to 2047, and check that they fold back correctly. A behavioural model reduces each exact sum or product by every modulus and is compared with the outputs on every cycle. This covers stretches of idle cycles with changing inputs, as well as switches between add and multiply on the same operands.

// File: rtl/rns_pkg.sv
package rns_pkg;

    // Moduli in digit order; the order fixes the field layout of a word.
    localparam int NDIG = 4;
    localparam int unsigned MODULI [NDIG] = '{5, 7, 9, 4};

    // Width of the scratch value that the reduction function works on.
    localparam int RED_W = 16;

    function automatic int digit_w(input int i);
        return $clog2(MODULI[i]);
    endfunction

    function automatic int digit_lo(input int i);
        int s;
        s = 0;
        for (int k = 0; k < i; k++) s += digit_w(k);
        return s;
    endfunction

    function automatic int range_of();
        int p;
        p = 1;
        for (int k = 0; k < NDIG; k++) p *= int'(MODULI[k]);
        return p;
    endfunction

    localparam int RES_W = digit_lo(NDIG);
    localparam int RANGE = range_of();
    localparam int BIN_W = $clog2(RANGE);

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } rns_op_e;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] val;
    } rns_out_t;

    // Restoring reduction: subtract shifted copies of m, largest first.
    function automatic logic [RED_W-1:0] mod_reduce(input logic [RED_W-1:0] x,
                                                    input int unsigned m);
        logic [RED_W-1:0] r;
        int unsigned      t;
        r = x;
        for (int k = RED_W - 1; k >= 0; k--) begin
            t = m << k;
            if (32'(r) >= t) r = r - RED_W'(t);
        end
        return r;
    endfunction

endpackage

// File: rtl/rns_encode.sv
module rns_encode
    import rns_pkg::*;
(
    input  logic [BIN_W-1:0] bin_in,
    output logic [RES_W-1:0] res_out
);

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        localparam int W  = digit_w(g);
        localparam int LO = digit_lo(g);
        always_comb begin
            res_out[LO +: W] = W'(mod_reduce(RED_W'(bin_in), MODULI[g]));
        end
    end

endmodule

// File: rtl/rns_lane.sv
module rns_lane
    import rns_pkg::*;
#(
    parameter int unsigned MOD = 5,
    parameter int          W   = $clog2(MOD)
) (
    input  rns_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    logic [RED_W-1:0] raw;

    always_comb begin
        if (op == OP_MUL) raw = RED_W'(a) * RED_W'(b);
        else              raw = RED_W'(a) + RED_W'(b);
        r = W'(mod_reduce(raw, MOD));
    end

endmodule

// File: rtl/rns_alu.sv
module rns_alu
    import rns_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             op_mul,
    input  logic [BIN_W-1:0] a_bin,
    input  logic [BIN_W-1:0] b_bin,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);

    logic [RES_W-1:0] a_res;
    logic [RES_W-1:0] b_res;
    logic [RES_W-1:0] lane_res;
    rns_op_e          op_sel;
    rns_out_t         out_q;

    assign op_sel = rns_op_e'(op_mul);

    rns_encode u_enc_a (.bin_in(a_bin), .res_out(a_res));
    rns_encode u_enc_b (.bin_in(b_bin), .res_out(b_res));

    for (genvar g = 0; g < NDIG; g++) begin : g_lane
        localparam int W  = digit_w(g);
        localparam int LO = digit_lo(g);
        rns_lane #(.MOD(MODULI[g]), .W(W)) u_lane (
            .op (op_sel),
            .a  (a_res[LO +: W]),
            .b  (b_res[LO +: W]),
            .r  (lane_res[LO +: W])
        );

        // R8
        digit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (32'(result[LO +: W]) < MODULI[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= in_valid;
            if (in_valid) out_q.val <= lane_res;
        end
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.val;

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

endmodule

// File: tb/rns_alu_bench.sv
module rns_alu_bench;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_mul = 1'b0;
    logic [10:0] a_bin = '0;
    logic [10:0] b_bin = '0;
    logic        out_valid;
    logic [11:0] result;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    bit    started  = 0;
    string phase    = "R7 reset";

    logic        m_vld;
    logic [11:0] m_res;

    always #(CLK_PER/2) clk = ~clk;

    rns_alu u_rns_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_mul(op_mul),
        .a_bin(a_bin), .b_bin(b_bin), .out_valid(out_valid), .result(result)
    );

    // R1 layout: [2:0] mod 5, [5:3] mod 7, [9:6] mod 9, [11:10] mod 4
    function automatic logic [11:0] pack_d(int d5, int d7, int d9, int d4);
        return {2'(d4), 4'(d9), 3'(d7), 3'(d5)};
    endfunction

    function automatic logic [11:0] pack_of(longint x);
        return pack_d(int'(x % 5), int'(x % 7), int'(x % 9), int'(x % 4));
    endfunction

    // Behavioural reference model, one register stage
    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_vld <= 0;
            m_res <= '0;
        end else begin
            m_vld <= in_valid;
            if (in_valid)
                m_res <= op_mul ? pack_of(longint'(a_bin) * longint'(b_bin))
                                : pack_of(longint'(a_bin) + longint'(b_bin));
        end
    end

    task automatic check(input logic [12:0] got, input logic [12:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Compare on every cycle, away from the rising edge (R5, R6, R8, R2, R3)
    always @(negedge clk) begin
        if (started && !done)
            check({out_valid, result}, {m_vld, m_res}, phase);
    end

    task automatic step(input int a, input int b, input bit mul, input bit vld, input string tag);
        @(negedge clk);
        a_bin = 11'(a); b_bin = 11'(b); op_mul = mul; in_valid = vld; phase = tag;
    endtask

    task automatic expect_lit(input logic [11:0] exp, input string tag);
        @(negedge clk);
        check({out_valid, result}, {1'b1, exp}, tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({out_valid, result}, 13'd0, "R7 reset state");
        @(negedge clk);
        rst = 0;

        step(29, 27, 0, 1, "R2 add 29+27");
        expect_lit(pack_d(1, 0, 2, 0), "R2 29+27");
        step(10, 17, 1, 1, "R3 mul 10*17");
        expect_lit(pack_d(0, 2, 8, 2), "R3 10*17");
        step(12, 0, 0, 1, "R9 encode 12");
        expect_lit(pack_d(2, 5, 3, 0), "R9 12");
        step(19, 1, 1, 1, "R9 encode 19");
        expect_lit(pack_d(4, 5, 1, 3), "R9 19");
        step(1289, 0, 0, 1, "R9 above range");
        expect_lit(pack_d(4, 1, 2, 1), "R9 1289 folds to 29");
        step(1259, 1, 0, 1, "R10 wrap add");
        expect_lit(pack_d(0, 0, 0, 0), "R10 1259+1");
        step(1259, 1259, 1, 1, "R10 wrap mul");
        expect_lit(pack_d(1, 1, 1, 1), "R10 1259*1259");
        step(3, 4, 0, 1, "R4 add select");
        expect_lit(pack_d(2, 0, 7, 3), "R4 3+4");
        step(3, 4, 1, 1, "R4 mul select");
        expect_lit(pack_d(2, 5, 3, 0), "R4 3*4");
        step(700, 900, 1, 0, "R6 idle hold");
        @(negedge clk);
        check({out_valid, result}, {1'b0, pack_d(2, 5, 3, 0)}, "R6 hold after idle");
        step(2047, 2047, 1, 1, "R9 max input mul");
        step(2047, 1, 0, 1, "R9 max input add");

        for (int v = 0; v < 20; v++) step(v, 0, 0, 1, "R9 sweep 0..19");

        for (int i = 0; i < 600; i++)
            step(int'($urandom_range(2047)), int'($urandom_range(2047)),
                 1'($urandom_range(1)), ($urandom_range(3) != 0),
                 "R2 R3 R6 R8 mixed stream");

        step(5, 5, 0, 1, "R7 reset mid-run");
        @(negedge clk);
        rst = 1; phase = "R7 reset mid-run";
        @(negedge clk);
        check({out_valid, result}, 13'd0, "R7 reset mid-run");
        rst = 0; in_valid = 0;
        repeat (2) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule